// File: doc/BRIEF.md
# Write-Read Ordering Protection Unit

This block sits between the memory stage of a pipelined processor and its memory bus. A write leaving the pipeline is parked for one or more cycles in a single-entry write holder before it goes onto the bus. A read that comes after it in program order is normally sent onto the bus ahead of that parked write. Most memory accepts this reordering, and it shortens read latency.

Peripheral registers often need their accesses in program order. The unit therefore holds a set of protected address windows, each with its own enable bit. When a read meets a parked write and either address falls in an enabled window, the read is stalled. The write goes onto the bus first, and the read follows in the cycle after the bus accepts the write. A read to the very address of the parked write is always ordered this way, whether or not the window is protected. Each cycle of this ordering stall raises a one-cycle pulse, so a performance counter can count the cost. The two peripheral frames that must be kept in order share one window group, and every window is enabled after reset.

Top module: `wro_unit`

## Requirements
- R1: After reset the unit drives no bus command, raises no stall and no stall pulse, and every protection window is enabled (the enable register resets to all ones).
- R2: A read to an address in no enabled window, while a write to a different address in no enabled window is parked, is issued on the bus in the same cycle with rd_stall low, and the parked write is issued after it.
- R3: When a read meets a parked write and either of the two addresses is in an enabled window, the bus carries the parked write (bus_we=1) and rd_stall stays high. The read is issued in the cycle after the write is accepted, so it is stalled for at least one cycle.
- R4: A read whose address equals the parked write address is ordered after that write even when neither address is in an enabled window.
- R5: While the bus holds bus_ready low, the parked write and the stalled read both wait. The ordering stall lasts until the cycle in which the write is accepted, and that cycle counts as a stall cycle.
- R6: stall_pulse is high in exactly the cycles in which a read is held for ordering, and it is never high without rd_stall.
- R7: A cycle with cfg_we high loads cfg_prot into the enable register (bit k enables window k). A window whose bit is 0 behaves as unprotected.
- R8: A write is taken into the holder when the holder is empty or is emptied onto the bus in that cycle. Otherwise wr_stall is high and the parked write keeps its address and data. Write data reaches bus_wdata unchanged.
- R9: A read presented in the same cycle as a write is older in program order. It is not checked against that write, and it is issued first.
- R10: Window k covers the addresses whose value shifted right by WIN_BITS equals BASE_WIN+k. With the defaults, window 0 is 0x6000–0x6FFF and window 1 is 0x7000–0x7FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load strobe for the protection enable register |
| cfg_prot | input | NREG | New window enable bits |
| wr_req | input | 1 | Write request from the pipeline |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| wr_stall | output | 1 | Write not taken this cycle |
| rd_req | input | 1 | Read request from the pipeline, held while stalled |
| rd_addr | input | AW | Read address |
| rd_stall | output | 1 | Read not completed this cycle |
| bus_valid | output | 1 | Bus command valid |
| bus_we | output | 1 | 1 = write command, 0 = read command |
| bus_addr | output | AW | Bus command address |
| bus_wdata | output | DW | Bus write data |
| bus_ready | input | 1 | Bus accepts the command this cycle |
| stall_pulse | output | 1 | High in each inserted ordering-stall cycle |

## Verification
Two things can compete for the single bus slot in one cycle: the drain of a parked write and the issue of a read. The bench sets up this contest by raising a read in the cycle right after a write, and again in the same cycle as a write, and varies the window enables, the addresses and periods of bus_ready low. A scoreboard lists the order in which the commands are expected on the bus, from the window map and the enable bits. The bench then compares the bus commands as they are accepted against that list and counts the stall pulses against the expected number of stall cycles.

// File: rtl/wro_pkg.sv
package wro_pkg;

  typedef enum logic [1:0] {
    GNT_NONE  = 2'd0,
    GNT_READ  = 2'd1,
    GNT_WRITE = 2'd2
  } grant_e;

  // Address falls in window number win_idx of size 2**win_bits.
  function automatic logic win_hit(input logic [31:0] addr,
                                   input int unsigned win_bits,
                                   input int unsigned win_idx);
    return (addr >> win_bits) == 32'(win_idx);
  endfunction

  // Ordering is needed when either side is protected or addresses match.
  function automatic logic needs_order(input logic rd_prot,
                                       input logic wp_prot,
                                       input logic same_addr);
    return rd_prot | wp_prot | same_addr;
  endfunction

endpackage

// File: rtl/wro_region_match.sv
module wro_region_match #(
  parameter int AW       = 16,
  parameter int NREG     = 2,
  parameter int WIN_BITS = 12,
  parameter int BASE_WIN = 6
) (
  input  logic [AW-1:0]   addr,
  input  logic [NREG-1:0] prot_en,
  output logic            hit
);
  import wro_pkg::*;

  logic [NREG-1:0] win_sel;

  for (genvar k = 0; k < NREG; k++) begin : g_win
    assign win_sel[k] = prot_en[k] & win_hit(32'(addr), WIN_BITS, BASE_WIN + k);
  end

  assign hit = |win_sel;

endmodule

// File: rtl/wro_wbuf.sv
module wro_wbuf #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          drain,
  output logic          wr_accept,
  output logic          wp_valid,
  output logic [AW-1:0] wp_addr,
  output logic [DW-1:0] wp_data
);

  assign wr_accept = wr_req & (~wp_valid | drain);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_valid <= 1'b0;
      wp_addr  <= '0;
      wp_data  <= '0;
    end else if (wr_accept) begin
      wp_valid <= 1'b1;
      wp_addr  <= wr_addr;
      wp_data  <= wr_data;
    end else if (drain) begin
      wp_valid <= 1'b0;
    end
  end

  AST_HOLD_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_valid && !drain) |=> (wp_valid && $stable(wp_addr) && $stable(wp_data))); // R8

endmodule

// File: rtl/wro_arbiter.sv
module wro_arbiter (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_req,
  input  logic            wp_valid,
  input  logic            hazard,
  input  logic            bus_ready,
  output wro_pkg::grant_e grant,
  output logic            rd_go,
  output logic            wr_drain,
  output logic            rd_stall,
  output logic            order_stall
);
  import wro_pkg::*;

  assign rd_go       = rd_req & ~hazard;
  assign order_stall = rd_req & hazard;
  assign wr_drain    = (grant == GNT_WRITE) & bus_ready;
  assign rd_stall    = rd_req & ~(rd_go & bus_ready);

  always_comb begin
    if (rd_go)         grant = GNT_READ;
    else if (wp_valid) grant = GNT_WRITE;
    else               grant = GNT_NONE;
  end

  AST_STALL_PULSE_IMPLIES_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    order_stall |-> rd_stall); // R6

  AST_WAIT_ON_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (order_stall && !bus_ready) |=> (wp_valid || !rd_req)); // R5

endmodule

// File: rtl/wro_unit.sv
module wro_unit #(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int NREG     = 2,
  parameter int WIN_BITS = 12,
  parameter int BASE_WIN = 6,
  parameter logic [NREG-1:0] PROT_RST = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [NREG-1:0] cfg_prot,
  input  logic            wr_req,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  output logic            wr_stall,
  input  logic            rd_req,
  input  logic [AW-1:0]   rd_addr,
  output logic            rd_stall,
  output logic            bus_valid,
  output logic            bus_we,
  output logic [AW-1:0]   bus_addr,
  output logic [DW-1:0]   bus_wdata,
  input  logic            bus_ready,
  output logic            stall_pulse
);
  import wro_pkg::*;

  logic [NREG-1:0] prot_en;
  logic            wr_accept, wp_valid, wr_drain, rd_go;
  logic [AW-1:0]   wp_addr;
  logic [DW-1:0]   wp_data;
  logic            rd_prot, wp_prot, same_addr, hazard;
  grant_e          grant;

  always_ff @(posedge clk) begin
    if (!rst_n)      prot_en <= PROT_RST;
    else if (cfg_we) prot_en <= cfg_prot;
  end

  wro_region_match #(.AW(AW), .NREG(NREG), .WIN_BITS(WIN_BITS), .BASE_WIN(BASE_WIN))
    u_rd_match (.addr(rd_addr), .prot_en(prot_en), .hit(rd_prot));

  wro_region_match #(.AW(AW), .NREG(NREG), .WIN_BITS(WIN_BITS), .BASE_WIN(BASE_WIN))
    u_wp_match (.addr(wp_addr), .prot_en(prot_en), .hit(wp_prot));

  wro_wbuf #(.AW(AW), .DW(DW)) u_wbuf (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .drain(wr_drain), .wr_accept(wr_accept), .wp_valid(wp_valid),
    .wp_addr(wp_addr), .wp_data(wp_data));

  assign same_addr = (rd_addr == wp_addr);
  assign hazard    = wp_valid & needs_order(rd_prot, wp_prot, same_addr);

  wro_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wp_valid(wp_valid), .hazard(hazard),
    .bus_ready(bus_ready), .grant(grant), .rd_go(rd_go), .wr_drain(wr_drain),
    .rd_stall(rd_stall), .order_stall(stall_pulse));

  assign wr_stall  = wr_req & ~wr_accept;
  assign bus_valid = (grant != GNT_NONE);
  assign bus_we    = (grant == GNT_WRITE);
  assign bus_addr  = rd_go ? rd_addr : wp_addr;
  assign bus_wdata = wp_data;

  AST_ORDER_WRITE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && hazard) |-> (bus_valid && bus_we && bus_addr == wp_addr)); // R3

  AST_SAME_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && wp_valid && rd_addr == wp_addr) |-> rd_stall); // R4

  AST_BYPASS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && wp_valid && !rd_prot && !wp_prot && rd_addr != wp_addr)
      |-> (bus_valid && !bus_we && bus_addr == rd_addr)); // R2

  AST_IDLE_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_req && !wp_valid) |-> !bus_valid); // R1

endmodule

// File: tb/wro_unit_bench.sv
`timescale 1ns/1ps
module wro_unit_bench;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int NREG = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [NREG-1:0] cfg_prot = '0;
  logic wr_req = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic wr_stall;
  logic rd_req = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic rd_stall, bus_valid, bus_we, stall_pulse;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic bus_ready = 1'b1;

  int n_chk = 0;
  int n_fail = 0;
  int hold = 0;
  int pulses;

  typedef struct { bit we; logic [AW-1:0] addr; logic [DW-1:0] data; string req; } item_t;
  item_t expq[$];

  always #2 clk = ~clk;

  wro_unit u_wro_unit (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_prot(cfg_prot),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_stall(wr_stall),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_stall(rd_stall),
    .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ready(bus_ready), .stall_pulse(stall_pulse));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input string req);
    item_t it;
    it.we = we; it.addr = a; it.data = d; it.req = req;
    expq.push_back(it);
  endtask

  // bus_ready driver: low for 'hold' cycles once armed
  initial forever begin
    @(posedge clk); #2;
    if (hold > 0) begin bus_ready = 1'b0; hold--; end
    else bus_ready = 1'b1;
  end

  // monitor: compare each accepted command with the scoreboard
  initial forever begin
    @(negedge clk);
    if (rst_n && bus_valid && bus_ready) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R2", "unexpected bus command addr", longint'(bus_addr), 0);
      end else begin
        item_t it;
        it = expq.pop_front();
        chk(bus_we == it.we, it.req, "bus_we", longint'(bus_we), longint'(it.we));
        chk(bus_addr == it.addr, it.req, "bus_addr", longint'(bus_addr), longint'(it.addr));
        if (it.we)
          chk(bus_wdata == it.data, "R8", "bus_wdata", longint'(bus_wdata), longint'(it.data));
      end
    end
  end

  // write one cycle, read the next; returns ordering stall pulses seen
  task automatic wr_then_rd(input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                            input logic [AW-1:0] ra, input int busy, output int np);
    np = 0;
    @(posedge clk); #1;
    wr_req = 1'b1; wr_addr = wa; wr_data = wd;
    @(posedge clk); #1;
    wr_req = 1'b0; rd_req = 1'b1; rd_addr = ra; hold = busy;
    forever begin
      @(negedge clk);
      if (stall_pulse) np++;
      if (!rd_stall) break;
      @(posedge clk); #1;
    end
    @(posedge clk); #1;
    rd_req = 1'b0;
    repeat (6) @(posedge clk);
  endtask

  initial begin : watchdog
    #200000;
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    chk(bus_valid == 1'b0, "R1", "bus_valid in reset", longint'(bus_valid), 0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    chk(bus_valid == 1'b0, "R1", "bus_valid after reset", longint'(bus_valid), 0);
    chk(rd_stall == 1'b0 && wr_stall == 1'b0, "R1", "stalls after reset",
        longint'({rd_stall, wr_stall}), 0);
    chk(stall_pulse == 1'b0, "R1", "stall_pulse after reset", longint'(stall_pulse), 0);

    // R2: unprotected, different addresses -> read overtakes
    push(0, 16'h2000, 0, "R2"); push(1, 16'h1000, 16'hA1A1, "R2");
    wr_then_rd(16'h1000, 16'hA1A1, 16'h2000, 0, pulses);
    chk(pulses == 0, "R2", "stall pulses", pulses, 0);

    // R1/R3: default-enabled window, protected write -> write first
    push(1, 16'h6010, 16'hB2B2, "R3"); push(0, 16'h2000, 0, "R3");
    wr_then_rd(16'h6010, 16'hB2B2, 16'h2000, 0, pulses);
    chk(pulses == 1, "R3", "stall pulses (write protected)", pulses, 1);

    // R3: protected read in window 1
    push(1, 16'h1000, 16'hC3C3, "R3"); push(0, 16'h7004, 0, "R3");
    wr_then_rd(16'h1000, 16'hC3C3, 16'h7004, 0, pulses);
    chk(pulses == 1, "R3", "stall pulses (read protected)", pulses, 1);

    // R4: same address, unprotected
    push(1, 16'h1234, 16'hD4D4, "R4"); push(0, 16'h1234, 0, "R4");
    wr_then_rd(16'h1234, 16'hD4D4, 16'h1234, 0, pulses);
    chk(pulses == 1, "R4", "stall pulses same address", pulses, 1);

    // R5/R6: bus busy for three cycles during the ordering stall
    push(1, 16'h6100, 16'hE5E5, "R5"); push(0, 16'h6200, 0, "R5");
    wr_then_rd(16'h6100, 16'hE5E5, 16'h6200, 3, pulses);
    chk(pulses == 4, "R6", "stall pulses with busy bus", pulses, 4);

    // R10: window edges
    push(0, 16'h1000, 0, "R10"); push(1, 16'h5FFF, 16'h0101, "R10");
    wr_then_rd(16'h5FFF, 16'h0101, 16'h1000, 0, pulses);
    chk(pulses == 0, "R10", "0x5FFF outside windows", pulses, 0);
    push(1, 16'h7FFF, 16'h0202, "R10"); push(0, 16'h1000, 0, "R10");
    wr_then_rd(16'h7FFF, 16'h0202, 16'h1000, 0, pulses);
    chk(pulses == 1, "R10", "0x7FFF inside window 1", pulses, 1);
    push(0, 16'h1000, 0, "R10"); push(1, 16'h8000, 16'h0303, "R10");
    wr_then_rd(16'h8000, 16'h0303, 16'h1000, 0, pulses);
    chk(pulses == 0, "R10", "0x8000 outside windows", pulses, 0);

    // R7: disable window 0 only
    @(posedge clk); #1; cfg_we = 1'b1; cfg_prot = 2'b10;
    @(posedge clk); #1; cfg_we = 1'b0;
    push(0, 16'h2000, 0, "R7"); push(1, 16'h6010, 16'hF6F6, "R7");
    wr_then_rd(16'h6010, 16'hF6F6, 16'h2000, 0, pulses);
    chk(pulses == 0, "R7", "disabled window stalls", pulses, 0);
    push(1, 16'h7010, 16'h0707, "R7"); push(0, 16'h2000, 0, "R7");
    wr_then_rd(16'h7010, 16'h0707, 16'h2000, 0, pulses);
    chk(pulses == 1, "R7", "still-enabled window stalls", pulses, 1);
    @(posedge clk); #1; cfg_we = 1'b1; cfg_prot = 2'b11;
    @(posedge clk); #1; cfg_we = 1'b0;

    // R9: read and write in the same cycle, both protected
    push(0, 16'h6000, 0, "R9"); push(1, 16'h6000, 16'h0909, "R9");
    @(posedge clk); #1;
    wr_req = 1'b1; wr_addr = 16'h6000; wr_data = 16'h0909;
    rd_req = 1'b1; rd_addr = 16'h6000;
    @(negedge clk);
    chk(rd_stall == 1'b0 && stall_pulse == 1'b0, "R9", "same-cycle read stall",
        longint'({rd_stall, stall_pulse}), 0);
    @(posedge clk); #1; wr_req = 1'b0; rd_req = 1'b0;
    repeat (4) @(posedge clk);

    // R8: back-to-back writes while the bus is busy
    push(1, 16'h3000, 16'h1111, "R8"); push(1, 16'h3002, 16'h2222, "R8");
    @(posedge clk); #1;
    wr_req = 1'b1; wr_addr = 16'h3000; wr_data = 16'h1111; hold = 3;
    @(negedge clk);
    chk(wr_stall == 1'b0, "R8", "first write taken", longint'(wr_stall), 0);
    @(posedge clk); #1;
    wr_addr = 16'h3002; wr_data = 16'h2222;
    @(negedge clk);
    chk(wr_stall == 1'b1, "R8", "second write stalled", longint'(wr_stall), 1);
    forever begin
      @(negedge clk);
      if (!wr_stall) break;
    end
    @(posedge clk); #1; wr_req = 1'b0;
    repeat (8) @(posedge clk);

    @(negedge clk);
    chk(expq.size() == 0, "R2", "scoreboard left over", expq.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule